// File: doc/BRIEF.md
# Fixed-Point Multi-Mode State-Variable Filter

This block is a two-integrator (Chamberlin) state-variable filter for a sample stream that runs far below the system clock. A single-cycle strobe marks the arrival of each signed 16-bit input sample. The filter then runs one update of its low-pass and band-pass integrators and derives the high-pass term. All of this arithmetic is sequenced over a few cycles through one shared multiplier and one shared adder. The filtered result leaves the block on the next strobe, so the latency is exactly one frame.

The response is set by a 12-bit unsigned cutoff coefficient and an 8-bit unsigned damping (resonance) coefficient. These values come straight from whatever maps user settings to coefficients. A 2-bit selector picks which of the three responses reaches the output. An enable input silences the output and clears the integrators. The internal state is kept at a fixed 24-bit width. Every product and every sum is brought back to that width with saturation, and the selected response is clamped to the 16-bit output range.

Top module: `svf_filter`

## Requirements
- R1: During and after reset, `out_valid` is 0, `sample_out` is 0, and both integrators hold 0. No valid pulse follows the first strobe after reset.
- R2: For every strobed sample, the filter computes these three steps in order, each using the newest values: hp = x − lp − ((damp·bp) >>> 8); then bp = bp + ((cut·hp) >>> 12); then lp = lp + ((cut·bp) >>> 12). Here x is the sample sign-extended to 24 bits, the coefficients are unsigned, and >>> is an arithmetic shift.
- R3: The response selector is captured with each sample. Value 00 outputs the low-pass term, 01 the band-pass term and 10 the high-pass term.
- R4: Selector value 11 outputs 0. The integrators keep updating as usual while it is set.
- R5: The selected 24-bit term is clamped to −32768..32767 before it drives `sample_out`.
- R6: Every rescaled product and every sum is clamped to the signed 24-bit range (−8388608..8388607) before it is stored or used, rather than wrapped.
- R7: A strobe with `enable` low clears both integrators. The result for that frame is 0, and the next enabled frame starts from zero state.
- R8: `out_valid` is high for exactly the one cycle after each strobe edge, starting with the second strobe after reset. It carries the result of the sample captured one strobe earlier, and `sample_out` holds its value between strobes.
- R9: The three-step update completes in fewer cycles than the frame length `FRAME_CYCLES` (50 by default), counted from the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle strobe marking a new input sample |
| sample_in | input | 16 | Signed input sample |
| enable | input | 1 | Filter enable, captured with the sample |
| mode | input | 2 | Response select: 00 low-pass, 01 band-pass, 10 high-pass, 11 silent |
| cutoff_k | input | 12 | Unsigned cutoff coefficient (scale 1/4096) |
| damp_q | input | 8 | Unsigned damping coefficient (scale 1/256) |
| sample_out | output | 16 | Signed filtered sample |
| out_valid | output | 1 | One-cycle pulse when `sample_out` is updated |

## Verification
Each result is due at the strobe that follows the strobe that captured its sample. It appears on the clock edge of that second strobe together with a one-cycle `out_valid` pulse. The bench raises the strobe at a falling edge and reads the outputs at the very next falling edge, just after the edge that registers them. It then checks that `out_valid` has dropped again near the end of the same frame. A bench model keeps its own integrators using the equations and clamps in the requirements. The model advances once per strobe, so every compared value is the one captured exactly one frame earlier.

// File: rtl/svf_pkg.sv
package svf_pkg;

   // Response selector encoding; the values are decoded from the mode port.
   typedef enum logic [1:0] {
      RESP_LOW  = 2'b00,
      RESP_BAND = 2'b01,
      RESP_HIGH = 2'b10,
      RESP_OFF  = 2'b11
   } resp_sel_e;

   // Arithmetic step inside one sample frame.
   typedef enum logic [1:0] {
      STEP_IDLE = 2'd0,
      STEP_HIGH = 2'd1,
      STEP_BAND = 2'd2,
      STEP_LOW  = 2'd3
   } calc_step_e;

   localparam int CALC_STEPS = 3;

endpackage

// File: rtl/svf_clamp.sv
module svf_clamp #(
   parameter int IN_W  = 26,
   parameter int OUT_W = 24
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);

   generate
      if (IN_W <= OUT_W) begin : g_extend
         assign dout = OUT_W'(din);
      end else begin : g_saturate
         logic [IN_W-OUT_W:0] top_bits;
         logic                fits;
         assign top_bits = din[IN_W-1:OUT_W-1];
         assign fits     = (&top_bits) | ~(|top_bits);
         always_comb begin
            if (fits)
               dout = din[OUT_W-1:0];
            else if (din[IN_W-1])
               dout = {1'b1, {(OUT_W-1){1'b0}}};
            else
               dout = {1'b0, {(OUT_W-1){1'b1}}};
         end
      end
   endgenerate

endmodule

// File: rtl/svf_mul.sv
module svf_mul #(
   parameter int A_W = 24,
   parameter int B_W = 12
) (
   input  logic signed [A_W-1:0]   op_a,
   input  logic        [B_W-1:0]   op_b,
   output logic signed [A_W+B_W:0] prod
);

   logic signed [B_W:0] b_signed;

   assign b_signed = signed'({1'b0, op_b});
   assign prod     = op_a * b_signed;

endmodule

// File: rtl/svf_core.sv
module svf_core
   import svf_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int STATE_W = 24,
   parameter int CUT_W   = 12,
   parameter int RES_W   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      clear,
   input  logic signed [DATA_W-1:0]  x_in,
   input  logic        [CUT_W-1:0]   cut_in,
   input  logic        [RES_W-1:0]   damp_in,
   output logic signed [STATE_W-1:0] lp_st,
   output logic signed [STATE_W-1:0] bp_st,
   output logic signed [STATE_W-1:0] hp_st,
   output logic                      busy
);

   localparam int COEF_W = (CUT_W > RES_W) ? CUT_W : RES_W;
   localparam int PROD_W = STATE_W + COEF_W + 1;
   localparam int SUM_W  = STATE_W + 2;

   calc_step_e                 step_q;
   logic signed [DATA_W-1:0]   x_q;
   logic        [CUT_W-1:0]    cut_q;
   logic        [RES_W-1:0]    damp_q;

   logic signed [STATE_W-1:0]  op_a;
   logic        [COEF_W-1:0]   op_b;
   logic signed [PROD_W-1:0]   prod;
   logic signed [PROD_W-1:0]   prod_shr;
   logic signed [STATE_W-1:0]  scaled;
   logic signed [SUM_W-1:0]    sum_w;
   logic signed [STATE_W-1:0]  next_val;

   // Operand routing for the single shared multiplier.
   always_comb begin
      op_a = (step_q == STEP_BAND) ? hp_st : bp_st;
      op_b = (step_q == STEP_HIGH) ? COEF_W'(damp_q) : COEF_W'(cut_q);
   end

   svf_mul #(.A_W(STATE_W), .B_W(COEF_W)) u_mul (
      .op_a (op_a),
      .op_b (op_b),
      .prod (prod)
   );

   assign prod_shr = (step_q == STEP_HIGH) ? (prod >>> RES_W) : (prod >>> CUT_W);

   svf_clamp #(.IN_W(PROD_W), .OUT_W(STATE_W)) u_prod_clamp (
      .din  (prod_shr),
      .dout (scaled)
   );

   // Shared adder: one of three sums depending on the step.
   always_comb begin
      case (step_q)
         STEP_HIGH: sum_w = SUM_W'(x_q) - SUM_W'(lp_st) - SUM_W'(scaled);
         STEP_BAND: sum_w = SUM_W'(bp_st) + SUM_W'(scaled);
         default:   sum_w = SUM_W'(lp_st) + SUM_W'(scaled);
      endcase
   end

   svf_clamp #(.IN_W(SUM_W), .OUT_W(STATE_W)) u_sum_clamp (
      .din  (sum_w),
      .dout (next_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         step_q <= STEP_IDLE;
         lp_st  <= '0;
         bp_st  <= '0;
         hp_st  <= '0;
         x_q    <= '0;
         cut_q  <= '0;
         damp_q <= '0;
      end else if (start) begin
         step_q <= STEP_HIGH;
         x_q    <= x_in;
         cut_q  <= cut_in;
         damp_q <= damp_in;
      end else begin
         case (step_q)
            STEP_HIGH: begin
               hp_st  <= next_val;
               step_q <= STEP_BAND;
            end
            STEP_BAND: begin
               bp_st  <= next_val;
               step_q <= STEP_LOW;
            end
            STEP_LOW: begin
               lp_st  <= next_val;
               step_q <= STEP_IDLE;
            end
            default: step_q <= STEP_IDLE;
         endcase
      end
   end

   assign busy = (step_q != STEP_IDLE);

endmodule

// File: rtl/svf_filter.sv
module svf_filter
   import svf_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int STATE_W      = 24,
   parameter int CUT_W        = 12,
   parameter int RES_W        = 8,
   parameter int FRAME_CYCLES = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_tick,
   input  logic [DATA_W-1:0] sample_in,
   input  logic              enable,
   input  logic [1:0]        mode,
   input  logic [CUT_W-1:0]  cutoff_k,
   input  logic [RES_W-1:0]  damp_q,
   output logic [DATA_W-1:0] sample_out,
   output logic              out_valid
);

   generate
      if (STATE_W <= DATA_W + 1) begin : g_bad_state_w
         $error("svf_filter: STATE_W must exceed DATA_W by at least 2");
      end
      if (FRAME_CYCLES <= CALC_STEPS + 1) begin : g_bad_frame
         $error("svf_filter: FRAME_CYCLES too short for the update sequence");
      end
      if (CUT_W < 1 || RES_W < 1) begin : g_bad_coef
         $error("svf_filter: coefficient widths must be positive");
      end
   endgenerate

   logic signed [STATE_W-1:0] lp_st;
   logic signed [STATE_W-1:0] bp_st;
   logic signed [STATE_W-1:0] hp_st;
   logic                      busy;
   resp_sel_e                 sel_q;
   logic                      en_q;
   logic                      primed;
   logic signed [STATE_W-1:0] sel_term;
   logic signed [DATA_W-1:0]  sel_clamped;

   svf_core #(
      .DATA_W (DATA_W),
      .STATE_W(STATE_W),
      .CUT_W  (CUT_W),
      .RES_W  (RES_W)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (sample_tick & enable),
      .clear  (sample_tick & ~enable),
      .x_in   (signed'(sample_in)),
      .cut_in (cutoff_k),
      .damp_in(damp_q),
      .lp_st  (lp_st),
      .bp_st  (bp_st),
      .hp_st  (hp_st),
      .busy   (busy)
   );

   always_comb begin
      case (sel_q)
         RESP_LOW:  sel_term = lp_st;
         RESP_BAND: sel_term = bp_st;
         RESP_HIGH: sel_term = hp_st;
         default:   sel_term = '0;
      endcase
   end

   svf_clamp #(.IN_W(STATE_W), .OUT_W(DATA_W)) u_out_clamp (
      .din  (sel_term),
      .dout (sel_clamped)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q      <= RESP_LOW;
         en_q       <= 1'b0;
         primed     <= 1'b0;
         out_valid  <= 1'b0;
         sample_out <= '0;
      end else if (sample_tick) begin
         sel_q     <= resp_sel_e'(mode);
         en_q      <= enable;
         primed    <= 1'b1;
         out_valid <= primed;
         if (primed)
            sample_out <= en_q ? sel_clamped : '0;
      end else begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/svf_filter_chk.sv
module svf_filter_chk #(
   parameter int STATE_W      = 24,
   parameter int DATA_W       = 16,
   parameter int FRAME_CYCLES = 50
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      sample_tick,
   input logic                      enable,
   input logic                      out_valid,
   input logic [DATA_W-1:0]         sample_out,
   input logic                      busy,
   input logic signed [STATE_W-1:0] lp_st,
   input logic signed [STATE_W-1:0] bp_st
);

   localparam int CW = $clog2(FRAME_CYCLES + 1) + 1;

   logic [CW-1:0] since_tick;

   always_ff @(posedge clk) begin
      if (!rst_n)
         since_tick <= '0;
      else if (sample_tick)
         since_tick <= CW'(1);
      else if (since_tick != {CW{1'b1}})
         since_tick <= since_tick + CW'(1);
   end

   // R8
   valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(sample_tick));

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample_tick) |-> $stable(sample_out));

   // R7
   disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sample_tick && !enable) |-> (lp_st == '0 && bp_st == '0));

   // R9
   frame_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (since_tick < CW'(FRAME_CYCLES)));

endmodule

bind svf_filter svf_filter_chk #(
   .STATE_W     (STATE_W),
   .DATA_W      (DATA_W),
   .FRAME_CYCLES(FRAME_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_tick(sample_tick),
   .enable     (enable),
   .out_valid  (out_valid),
   .sample_out (sample_out),
   .busy       (busy),
   .lp_st      (lp_st),
   .bp_st      (bp_st)
);

// File: tb/svf_filter_test.sv
module svf_filter_test;

   localparam int FRAME = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_tick = 1'b0;
   logic [15:0] sample_in = '0;
   logic        enable = 1'b0;
   logic [1:0]  mode = '0;
   logic [11:0] cutoff_k = '0;
   logic [7:0]  damp_q = '0;
   logic [15:0] sample_out;
   logic        out_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   longint m_lp = 0, m_bp = 0, m_hp = 0;
   longint exp_out = 0;
   bit     pending = 1'b0;

   always #5 clk = ~clk;

   svf_filter uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_tick(sample_tick),
      .sample_in  (sample_in),
      .enable     (enable),
      .mode       (mode),
      .cutoff_k   (cutoff_k),
      .damp_q     (damp_q),
      .sample_out (sample_out),
      .out_valid  (out_valid)
   );

   function automatic longint sat(input longint v, input int w);
      longint hi = (longint'(1) <<< (w - 1)) - 1;
      longint lo = -(longint'(1) <<< (w - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   task automatic chk(input string req, input longint act, input longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   // One sample frame: strobe, compare the previous frame's result, advance the model.
   task automatic frame(input logic signed [15:0] x, input logic [11:0] c,
                        input logic [7:0] r, input logic [1:0] m,
                        input logic en, input string req);
      longint sel;
      @(negedge clk);
      sample_in = x; cutoff_k = c; damp_q = r; mode = m; enable = en;
      sample_tick = 1'b1;
      @(negedge clk);
      sample_tick = 1'b0;
      if (pending) begin
         // R8: valid in the cycle after the strobe edge; R9: result ready by then
         chk({req, " R8 valid"}, longint'(out_valid), 1);
         chk(req, longint'(signed'(sample_out)), exp_out);
      end else begin
         chk("R1 no valid on first strobe", longint'(out_valid), 0);
      end
      if (en) begin
         m_hp = sat(longint'(x) - m_lp - sat((m_bp * longint'(r)) >>> 8, 24), 24);
         m_bp = sat(m_bp + sat((m_hp * longint'(c)) >>> 12, 24), 24);
         m_lp = sat(m_lp + sat((m_bp * longint'(c)) >>> 12, 24), 24);
         case (m)
            2'b00:   sel = m_lp;
            2'b01:   sel = m_bp;
            2'b10:   sel = m_hp;
            default: sel = 0;
         endcase
         exp_out = sat(sel, 16);
      end else begin
         m_lp = 0; m_bp = 0; m_hp = 0;
         exp_out = 0;
      end
      pending = 1'b1;
      repeat (FRAME - 2) @(negedge clk);
      chk("R8 valid low mid-frame", longint'(out_valid), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", longint'(out_valid), 0);
      chk("R1 output in reset", longint'(sample_out), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 valid after reset", longint'(out_valid), 0);
      chk("R1 output after reset", longint'(sample_out), 0);
   endtask

   task automatic t_lowpass_step();
      for (int k = 0; k < 20; k++) frame(16'sd10000, 12'd1024, 8'd128, 2'b00, 1'b1, "R2 R3 low-pass step");
   endtask

   task automatic t_bandpass();
      for (int k = 0; k < 20; k++)
         frame(k[1] ? -16'sd12000 : 16'sd12000, 12'd700, 8'd60, 2'b01, 1'b1, "R2 R3 band-pass");
   endtask

   task automatic t_highpass();
      for (int k = 0; k < 20; k++)
         frame(k[0] ? 16'sd3000 : -16'sd9000, 12'd300, 8'd200, 2'b10, 1'b1, "R2 R3 high-pass");
   endtask

   task automatic t_reserved();
      for (int k = 0; k < 6; k++) frame(16'sd8000, 12'd900, 8'd100, 2'b11, 1'b1, "R4 reserved select");
      for (int k = 0; k < 4; k++) frame(16'sd8000, 12'd900, 8'd100, 2'b00, 1'b1, "R4 state kept");
   endtask

   task automatic t_clamp();
      for (int k = 0; k < 30; k++) frame(16'sh7FFF, 12'd4095, 8'd0, 2'b00, 1'b1, "R5 output clamp");
   endtask

   task automatic t_saturate();
      for (int k = 0; k < 700; k++)
         frame(((k / 3) % 2 == 1) ? -16'sd32768 : 16'sd32767, 12'd4095, 8'd0,
               k[0] ? 2'b01 : 2'b00, 1'b1, "R6 state saturation");
   endtask

   task automatic t_disable();
      for (int k = 0; k < 5; k++) frame(16'sd20000, 12'd2000, 8'd50, 2'b00, 1'b0, "R7 disabled");
      for (int k = 0; k < 8; k++) frame(16'sd20000, 12'd2000, 8'd50, 2'b00, 1'b1, "R7 restart from zero");
   endtask

   initial begin
      t_reset();
      t_lowpass_step();
      t_bandpass();
      t_highpass();
      t_reserved();
      t_clamp();
      t_disable();
      t_saturate();
      t_disable();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual running expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule